// File: doc/BRIEF.md
# Three-Level Page Table Walker with Guest-Physical Stage

This block translates a 64-bit address into a 56-bit physical address. It walks a three-level radix page table held in memory, reading one 64-bit table entry at a time. A requester hands it one translation at a time: the address, the kind of access (read, write or fetch), whether the access comes from user or supervisor privilege, which stage is wanted, and the page number of the root table. The walker then issues entry reads on a valid/ready memory port. At the end it returns either the physical address or a page fault, together with the table level at which the walk stopped.

Two stages are supported. In the ordinary stage the input address is 39 bits, sign-extended to 64. In the guest-physical stage the input is 41 bits, zero-extended. That stage uses a root table four times as large (16 KiB), indexed by 11 address bits. Leaf entries may sit at any level, which gives 4 KiB, 2 MiB or 1 GiB pages. The walker checks superpage alignment and the permission bits before it reports success. It keeps no translation cache and never writes to the tables.

Top module: `ptw39_walker`

## Requirements
- R1: `req_ready` is high only while no walk is in progress. A request is taken when `req_valid` and `req_ready` are both high, and at most one walk is active at a time.
- R2: In the ordinary stage (`req_gstage`=0), if address bits 63..39 are not all equal to bit 38, the walker returns a fault at level 2 and makes no memory read.
- R3: In the guest-physical stage (`req_gstage`=1), if any of address bits 63..41 is set, the walker returns a fault at level 2 and makes no memory read.
- R4: The first entry read goes to `root`·4096 + idx·8. The index idx is address bits 38..30 in the ordinary stage and address bits 40..30 in the guest-physical stage.
- R5: Table entries use this layout: bit 0 valid, bit 1 read, bit 2 write, bit 3 execute, bit 4 user, and bits 53..10 the page number. An entry that is valid and has read=0, write=0 and execute=0 is a pointer. The next read goes to its page number·4096 + idx·8, where idx is address bits 29..21 at level 1 and bits 20..12 at level 0.
- R6: An entry with valid=0, or with read=0 and write=1, ends the walk with a fault at the level where that entry was read.
- R7: A pointer entry read at level 0 ends the walk with a fault at level 0.
- R8: On a leaf, `req_acc` 0 (read) and 3 need the read bit, 1 (write) needs the write bit, and 2 (fetch) needs the execute bit. The privilege is user when `req_smode`=0 or when the guest-physical stage is selected; a user access needs user=1 and a supervisor access needs user=0. Any other combination faults at the leaf's level.
- R9: A leaf at level 1 whose page number bits 8..0 are non-zero, or a leaf at level 2 whose bits 17..0 are non-zero, faults at that level.
- R10: On success, the low 12+9·L physical address bits equal the input address bits, and the higher bits come from the leaf's page number. L is the leaf level, and `rsp_level` reports L.
- R11: `mem_req_valid` and `mem_req_addr` stay steady until `mem_req_ready`. `rsp_valid` and the response fields stay steady until `rsp_ready`.
- R12: A faulting response always carries `rsp_paddr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 64 | Address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| req_smode | input | 1 | 1 supervisor, 0 user |
| req_gstage | input | 1 | 1 selects the guest-physical stage |
| req_root | input | 44 | Root table page number |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 56 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data present (one cycle) |
| mem_rsp_data | input | 64 | Entry data |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_fault | output | 1 | Page fault |
| rsp_level | output | 2 | Level where the walk stopped |
| rsp_paddr | output | 56 | Physical address, zero on fault |

## Verification
Some rules can be checked on every cycle. The assertions cover the one-walk-at-a-time handshake, the holding of the memory request and of the response while stalled, the 8-byte alignment of entry addresses, the zero address on faults, and the immediate fault on a bad upper address in either stage. The rest can only be shown by the bench's scenarios, because each depends on the table contents it supplies. That covers the address of each entry read, the handling of pointers and of reserved encodings, the permission and privilege decision, the misaligned-superpage rule, and how the physical address is assembled for each page size.

// File: rtl/ptw39_pkg.sv
package ptw39_pkg;
  localparam int VA_W        = 64;
  localparam int PA_W        = 56;
  localparam int PTE_W       = 64;
  localparam int PPN_W       = 44;
  localparam int PAGE_OFF_W  = 12;
  localparam int VPN_W       = 9;
  localparam int LEVELS      = 3;
  localparam int LVL_W       = $clog2(LEVELS);
  localparam int SV_VA_W     = PAGE_OFF_W + VPN_W * LEVELS;
  localparam int G_ROOT_XTRA = 2;
  localparam int G_VA_W      = SV_VA_W + G_ROOT_XTRA;
  localparam int ROOT_IDX_W  = VPN_W + G_ROOT_XTRA;
  localparam int PTE_SHIFT   = $clog2(PTE_W / 8);
  localparam int UPPER_W     = VA_W - SV_VA_W + 1;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_ALT   = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_DONE
  } walk_st_e;

  typedef struct packed {
    logic [PTE_W-PPN_W-10-1:0] hi;
    logic [PPN_W-1:0]          ppn;
    logic [1:0]                sw;
    logic                      d;
    logic                      a;
    logic                      g;
    logic                      u;
    logic                      x;
    logic                      w;
    logic                      r;
    logic                      v;
  } pte_t;

  // Index into the table at the given level; the top level of the
  // guest-physical stage takes the wider root index.
  function automatic logic [ROOT_IDX_W-1:0] vpn_index(
    input logic [G_VA_W-1:0] va,
    input logic [LVL_W-1:0]  lvl,
    input logic              guest
  );
    logic [ROOT_IDX_W-1:0] idx;
    idx = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (int'(lvl) == l) idx = ROOT_IDX_W'(va[PAGE_OFF_W + VPN_W*l +: VPN_W]);
    end
    if (guest && int'(lvl) == LEVELS - 1)
      idx = va[PAGE_OFF_W + VPN_W*(LEVELS-1) +: ROOT_IDX_W];
    return idx;
  endfunction

  // Byte address of an entry: table page base plus scaled index.
  function automatic logic [PA_W-1:0] entry_addr(
    input logic [PPN_W-1:0]      base,
    input logic [ROOT_IDX_W-1:0] idx
  );
    return {base, {PAGE_OFF_W{1'b0}}} + PA_W'({idx, {PTE_SHIFT{1'b0}}});
  endfunction
endpackage

// File: rtl/ptw39_precheck.sv
module ptw39_precheck
  import ptw39_pkg::*;
(
  input  logic [UPPER_W-1:0] va_upper,
  input  logic               guest,
  output logic               upper_ok
);
  localparam int G_LO = G_VA_W - SV_VA_W + 1;

  logic sv_ok;
  logic g_ok;

  assign sv_ok    = (&va_upper) | ~(|va_upper);
  assign g_ok     = ~(|va_upper[UPPER_W-1:G_LO]);
  assign upper_ok = guest ? g_ok : sv_ok;
endmodule

// File: rtl/ptw39_pte_eval.sv
module ptw39_pte_eval
  import ptw39_pkg::*;
(
  input  logic             f_v,
  input  logic             f_r,
  input  logic             f_w,
  input  logic             f_x,
  input  logic             f_u,
  input  logic [PPN_W-1:0] ppn,
  input  logic [LVL_W-1:0] level,
  input  logic [1:0]       acc,
  input  logic             smode,
  input  logic             guest,
  output logic             is_invalid,
  output logic             is_pointer,
  output logic             perm_ok,
  output logic             misaligned
);
  logic             as_user;
  logic             priv_ok;
  logic             kind_ok;
  logic [PPN_W-1:0] low_mask;

  assign is_invalid = ~f_v | (~f_r & f_w);
  assign is_pointer = ~is_invalid & ~f_r & ~f_x;

  assign as_user = guest | ~smode;
  assign priv_ok = as_user ? f_u : ~f_u;

  always_comb begin
    unique case (acc_e'(acc))
      ACC_STORE: kind_ok = f_w;
      ACC_FETCH: kind_ok = f_x;
      default:   kind_ok = f_r;
    endcase
  end

  assign perm_ok    = priv_ok & kind_ok;
  assign low_mask   = (PPN_W'(1) << (VPN_W * int'(level))) - PPN_W'(1);
  assign misaligned = |(ppn & low_mask);
endmodule

// File: rtl/ptw39_pa_form.sv
module ptw39_pa_form
  import ptw39_pkg::*;
(
  input  logic [PAGE_OFF_W+VPN_W*(LEVELS-1)-1:0] va_low,
  input  logic [PPN_W-1:0]                       ppn,
  input  logic [LVL_W-1:0]                       level,
  output logic [PA_W-1:0]                        pa
);
  localparam int TOP_LO = VPN_W * (LEVELS - 1);

  assign pa[PAGE_OFF_W-1:0] = va_low[PAGE_OFF_W-1:0];

  for (genvar g = 0; g < LEVELS - 1; g++) begin : g_field
    assign pa[PAGE_OFF_W + g*VPN_W +: VPN_W] =
      (int'(level) > g) ? va_low[PAGE_OFF_W + g*VPN_W +: VPN_W]
                        : ppn[g*VPN_W +: VPN_W];
  end

  assign pa[PA_W-1:PAGE_OFF_W+TOP_LO] = ppn[PPN_W-1:TOP_LO];
endmodule

// File: rtl/ptw39_walker.sv
module ptw39_walker
  import ptw39_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_acc,
  input  logic              req_smode,
  input  logic              req_gstage,
  input  logic [PPN_W-1:0]  req_root,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_fault,
  output logic [LVL_W-1:0]  rsp_level,
  output logic [PA_W-1:0]   rsp_paddr
);
  walk_st_e          st_q;
  logic [G_VA_W-1:0] va_q;
  logic [1:0]        acc_q;
  logic              smode_q;
  logic              guest_q;
  logic [PPN_W-1:0]  base_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              fault_q;
  logic [PA_W-1:0]   pa_q;

  pte_t      pte_in;
  logic      upper_ok;
  logic      is_invalid;
  logic      is_pointer;
  logic      perm_ok;
  logic      misaligned;
  logic [PA_W-1:0] leaf_pa;

  // Named internal events
  logic walk_accept;
  logic pte_take;
  logic step_down;
  logic leaf_ok;
  logic walk_fault;

  assign pte_in = pte_t'(mem_rsp_data);

  logic unused_pte_bits;
  assign unused_pte_bits = ^{pte_in.hi, pte_in.sw, pte_in.d, pte_in.a, pte_in.g};

  ptw39_precheck u_pre (
    .va_upper (req_vaddr[VA_W-1:SV_VA_W-1]),
    .guest    (req_gstage),
    .upper_ok (upper_ok)
  );

  ptw39_pte_eval u_eval (
    .f_v        (pte_in.v),
    .f_r        (pte_in.r),
    .f_w        (pte_in.w),
    .f_x        (pte_in.x),
    .f_u        (pte_in.u),
    .ppn        (pte_in.ppn),
    .level      (lvl_q),
    .acc        (acc_q),
    .smode      (smode_q),
    .guest      (guest_q),
    .is_invalid (is_invalid),
    .is_pointer (is_pointer),
    .perm_ok    (perm_ok),
    .misaligned (misaligned)
  );

  ptw39_pa_form u_pa (
    .va_low (va_q[PAGE_OFF_W+VPN_W*(LEVELS-1)-1:0]),
    .ppn    (pte_in.ppn),
    .level  (lvl_q),
    .pa     (leaf_pa)
  );

  assign walk_accept = req_valid & req_ready;
  assign pte_take    = (st_q == ST_WAIT) & mem_rsp_valid;
  assign step_down   = pte_take & is_pointer & (lvl_q != '0);
  assign leaf_ok     = pte_take & ~is_invalid & ~is_pointer & perm_ok & ~misaligned;
  assign walk_fault  = pte_take & ~step_down & ~leaf_ok;

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_REQ);
  assign mem_req_addr  = entry_addr(base_q, vpn_index(va_q, lvl_q, guest_q));
  assign rsp_valid     = (st_q == ST_DONE);
  assign rsp_fault     = fault_q;
  assign rsp_level     = lvl_q;
  assign rsp_paddr     = pa_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      va_q    <= '0;
      acc_q   <= '0;
      smode_q <= 1'b0;
      guest_q <= 1'b0;
      base_q  <= '0;
      lvl_q   <= '0;
      fault_q <= 1'b0;
      pa_q    <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (walk_accept) begin
            va_q    <= req_vaddr[G_VA_W-1:0];
            acc_q   <= req_acc;
            smode_q <= req_smode;
            guest_q <= req_gstage;
            base_q  <= req_root;
            lvl_q   <= LVL_W'(LEVELS - 1);
            fault_q <= ~upper_ok;
            pa_q    <= '0;
            st_q    <= upper_ok ? ST_REQ : ST_DONE;
          end
        end
        ST_REQ: begin
          if (mem_req_ready) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (step_down) begin
            lvl_q  <= lvl_q - LVL_W'(1);
            base_q <= pte_in.ppn;
            st_q   <= ST_REQ;
          end else if (pte_take) begin
            fault_q <= walk_fault;
            pa_q    <= leaf_ok ? leaf_pa : '0;
            st_q    <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (rsp_ready) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw39_walker_chk.sv
module ptw39_walker_chk
  import ptw39_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic [UPPER_W-1:0] va_hi,
  input logic               req_gstage,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic [PA_W-1:0]    mem_req_addr,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic               rsp_fault,
  input logic [LVL_W-1:0]   rsp_level,
  input logic [PA_W-1:0]    rsp_paddr
);
  localparam int G_LO = G_VA_W - SV_VA_W + 1;

  logic taken;
  logic sv_bad;
  logic g_bad;

  assign taken  = req_valid & req_ready;
  assign sv_bad = ($countones(va_hi) != 0) && ($countones(va_hi) != UPPER_W);
  assign g_bad  = va_hi[UPPER_W-1:G_LO] != '0;

  assert_single_walk_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !rsp_valid));

  assert_sv_upper_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !req_gstage && sv_bad) |=> (rsp_valid && rsp_fault && rsp_level == LVL_W'(LEVELS-1)));

  assert_guest_upper_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && req_gstage && g_bad) |=> (rsp_valid && rsp_fault && rsp_level == LVL_W'(LEVELS-1)));

  assert_entry_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[PTE_SHIFT-1:0] == '0));

  assert_memreq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable({rsp_fault, rsp_level, rsp_paddr})));

  assert_fault_zero_pa_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));
endmodule

bind ptw39_walker ptw39_walker_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .va_hi         (req_vaddr[ptw39_pkg::VA_W-1:ptw39_pkg::SV_VA_W-1]),
  .req_gstage    (req_gstage),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_fault     (rsp_fault),
  .rsp_level     (rsp_level),
  .rsp_paddr     (rsp_paddr)
);

// File: tb/ptw39_walker_tb.sv
`timescale 1ns/1ps
module ptw39_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        req_smode = 1'b0;
  logic        req_gstage = 1'b0;
  logic [43:0] req_root = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [55:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_fault;
  logic [1:0]  rsp_level;
  logic [55:0] rsp_paddr;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  ptw39_walker u_dut (.*);

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL R1 watchdog expired actual=%0d expected<=150000", cyc);
      report();
      $finish;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model results
  logic [55:0] m_addr[3];
  int          m_n;
  logic        m_fault;
  logic [1:0]  m_lvl;
  logic [55:0] m_pa;

  task automatic model(logic [63:0] va, logic [1:0] acc, logic s, logic g,
                       logic [43:0] root, logic [63:0] p0, logic [63:0] p1, logic [63:0] p2);
    logic [63:0] p[3];
    logic [63:0] base, idx, pte, ppn, lowmask;
    logic ok, usr;
    p[0] = p0; p[1] = p1; p[2] = p2;
    m_n = 0; m_fault = 1'b0; m_pa = '0; m_lvl = 2'd2;
    if (g ? ((va >> 41) != 0) : !((va >> 38) == 0 || (va >> 38) == 64'h3FFFFFF)) begin
      m_fault = 1'b1;
      return;
    end
    base = 64'(root);
    for (int i = 2; i >= 0; i--) begin
      idx = (va >> (12 + 9*i)) & ((64'd1 << ((i == 2 && g) ? 11 : 9)) - 1);
      m_addr[m_n] = 56'((base << 12) + idx * 8);
      pte = p[m_n];
      m_n++;
      m_lvl = 2'(i);
      ppn = (pte >> 10) & ((64'd1 << 44) - 1);
      if (!pte[0] || (!pte[1] && pte[2])) begin m_fault = 1'b1; return; end
      if (!pte[1] && !pte[3]) begin
        if (i == 0) begin m_fault = 1'b1; return; end
        base = ppn;
        continue;
      end
      usr = g || !s;
      ok = (usr == pte[4]) && ((acc == 2'd1) ? pte[2] : (acc == 2'd2) ? pte[3] : pte[1]);
      lowmask = (64'd1 << (12 + 9*i)) - 1;
      if (!ok || (((ppn << 12) & lowmask) != 0)) begin m_fault = 1'b1; return; end
      m_pa = 56'(((ppn << 12) & ~lowmask) | (va & lowmask));
      return;
    end
  endtask

  task automatic walk(string tag, logic [63:0] va, logic [1:0] acc, logic s, logic g,
                      logic [43:0] root, logic [63:0] p0, logic [63:0] p1, logic [63:0] p2);
    logic [63:0] p[3];
    int k = 0;
    bit done = 0;
    logic [55:0] hold_pa;
    p[0] = p0; p[1] = p1; p[2] = p2;
    model(va, acc, s, g, root, p0, p1, p2);
    @(negedge clk);
    chk({tag, " R1 ready when idle"}, 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_vaddr = va; req_acc = acc; req_smode = s;
    req_gstage = g; req_root = root;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R1 busy after accept"}, 64'(req_ready), 64'd0);
    for (int it = 0; it < 80 && !done; it++) begin
      if (rsp_valid) begin
        chk({tag, " read count"}, 64'(k), 64'(m_n));
        chk({tag, " fault"}, 64'(rsp_fault), 64'(m_fault));
        chk({tag, " level"}, 64'(rsp_level), 64'(m_lvl));
        chk({tag, " paddr R10 R12"}, 64'(rsp_paddr), 64'(m_pa));
        hold_pa = rsp_paddr;
        repeat ($urandom % 3) @(negedge clk);
        chk({tag, " R11 response held"}, 64'({rsp_valid, rsp_paddr}), 64'({1'b1, hold_pa}));
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        done = 1;
      end else if (mem_req_valid) begin
        if (k < m_n) chk({tag, " R4 R5 entry address"}, 64'(mem_req_addr), 64'(m_addr[k]));
        else chk({tag, " R2 R3 unexpected read"}, 64'(k), 64'(m_n));
        repeat ($urandom % 2) @(negedge clk);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat ($urandom % 2) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data = (k < 3) ? p[k] : 64'd0;
        k++;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_data = {$urandom, $urandom};
      end else begin
        @(negedge clk);
      end
    end
    if (!done) chk({tag, " R1 walk never finished"}, 64'd0, 64'd1);
  endtask

  function automatic logic [63:0] mk(logic [43:0] ppn, logic [7:0] fl);
    return {10'd0, ppn, 2'd0, fl};
  endfunction

  function automatic logic [63:0] rnd_pte();
    logic [43:0] ppn;
    logic [7:0]  fl;
    int kind;
    kind = int'($urandom % 8);
    ppn = 44'({$urandom, $urandom});
    if ($urandom % 2) ppn[17:0] = '0;
    case (kind)
      0: fl = 8'($urandom) & 8'hFE;
      1: fl = 8'h05 | (8'($urandom % 2) << 3) | (8'($urandom % 2) << 4);
      2, 3, 4: fl = 8'h01;
      default: begin
        fl = {3'd0, 4'($urandom), 1'b1};
        if (!fl[1] && !fl[3]) fl[1] = 1'b1;
      end
    endcase
    return {10'($urandom), ppn, 2'($urandom), fl};
  endfunction

  localparam logic [7:0] PTR = 8'h01;

  initial begin
    logic [63:0] va;
    logic [43:0] root;
    logic g;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ready", 64'(req_ready), 64'd1);
    chk("R1 reset no read", 64'(mem_req_valid), 64'd0);
    chk("R1 reset no response", 64'(rsp_valid), 64'd0);

    // 4 KiB page, user read
    walk("R10 4K", 64'h0000_0012_3456_7ABC, 2'd0, 1'b0, 1'b0, 44'h12345,
         mk(44'h100, PTR), mk(44'h200, PTR), mk(44'hABCDE, 8'h13));
    // 2 MiB superpage
    walk("R10 2M", 64'h0000_0034_5678_9DEF, 2'd0, 1'b0, 1'b0, 44'h00777,
         mk(44'h300, PTR), mk(44'h12345 << 9, 8'h13), 64'd0);
    // 1 GiB superpage, fetch
    walk("R10 1G", 64'h0000_0015_5555_5123, 2'd2, 1'b0, 1'b0, 44'h00888,
         mk(44'h7 << 18, 8'h19), 64'd0, 64'd0);
    // Negative canonical address, supervisor leaf
    walk("R2 canonical high", 64'hFFFF_FFC0_1234_5000, 2'd0, 1'b1, 1'b0, 44'h00999,
         mk(44'h400, PTR), mk(44'h500, PTR), mk(44'h600, 8'h03));
    walk("R9 misaligned 2M", 64'h0000_0000_0020_0000, 2'd0, 1'b0, 1'b0, 44'h1,
         mk(44'h2, PTR), mk(44'h12345, 8'h13), 64'd0);
    walk("R9 misaligned 1G", 64'h0000_0000_4000_0000, 2'd0, 1'b0, 1'b0, 44'h1,
         mk(44'h200, 8'h13), 64'd0, 64'd0);
    walk("R7 pointer at level 0", 64'h0, 2'd0, 1'b0, 1'b0, 44'h5,
         mk(44'h6, PTR), mk(44'h7, PTR), mk(44'h8, PTR));
    walk("R6 not valid", 64'h0000_0000_1234_5000, 2'd0, 1'b0, 1'b0, 44'h5,
         mk(44'h6, PTR), mk(44'h7, 8'h1E), 64'd0);
    walk("R6 write without read", 64'h0, 2'd1, 1'b0, 1'b0, 44'h5,
         mk(44'h6, 8'h15), 64'd0, 64'd0);
    walk("R2 noncanonical", 64'h0000_0080_0000_0000, 2'd0, 1'b0, 1'b0, 44'h5,
         64'd0, 64'd0, 64'd0);
    walk("R3 guest upper bit", 64'h0000_0200_0000_0000, 2'd0, 1'b0, 1'b1, 44'h4,
         64'd0, 64'd0, 64'd0);
    walk("R4 guest wide index", 64'h0000_01FF_C000_0123, 2'd0, 1'b1, 1'b1, 44'h1000,
         mk(44'h40, PTR), mk(44'h50, PTR), mk(44'h60, 8'h13));
    walk("R8 supervisor on user page", 64'h1000, 2'd0, 1'b1, 1'b0, 44'h5,
         mk(44'h6, PTR), mk(44'h7, PTR), mk(44'h8, 8'h13));
    walk("R8 guest needs user bit", 64'h1000, 2'd0, 1'b1, 1'b1, 44'h4,
         mk(44'h6, PTR), mk(44'h7, PTR), mk(44'h8, 8'h03));
    walk("R8 write denied", 64'h1000, 2'd1, 1'b0, 1'b0, 44'h5,
         mk(44'h6, PTR), mk(44'h7, PTR), mk(44'h8, 8'h13));
    walk("R8 fetch only page read", 64'h1000, 2'd3, 1'b0, 1'b0, 44'h5,
         mk(44'h6, PTR), mk(44'h7, PTR), mk(44'h8, 8'h19));
    walk("R8 fetch allowed", 64'h1000, 2'd2, 1'b0, 1'b0, 44'h5,
         mk(44'h6, PTR), mk(44'h7, PTR), mk(44'h8, 8'h19));

    for (int n = 0; n < 400; n++) begin
      g = 1'($urandom % 2);
      va = {$urandom, $urandom};
      root = 44'({$urandom, $urandom});
      if (g) begin
        root[1:0] = 2'b00;
        if ($urandom % 8 != 0) va[63:41] = '0;
      end else if ($urandom % 8 != 0) begin
        va[63:39] = {25{va[38]}};
      end
      walk("R5 R8 R10 random", va, 2'($urandom), 1'($urandom), g, root,
           rnd_pte(), rnd_pte(), rnd_pte());
    end

    report();
    $finish;
  end
endmodule